// File: doc/BRIEF.md
# Nested Four-Level Interrupt Priority Arbiter

The arbiter collects pending requests from seven interrupt sources: two external pins, two timer overflows, a brownout request, an ADC completion request and an edge-detect request. It masks them with one enable bit per source and a global enable. Each source gets a two-bit level from a separate high-priority bit and low-priority bit. The arbiter picks one request to hand to the CPU. A request may interrupt running code only when its level is strictly above every level already in service.

When the CPU accepts the request with `ack`, the arbiter does four things. It pushes the level of the winner onto an in-service record. It presents the source index with a one-cycle `vec_valid` strobe. It clears the external-pin flag of the winner when that pin is in edge mode, or sends a one-cycle clear pulse back to the timer block when the winner is a timer. A single `reti` pulse from the return-from-interrupt decode pops the most recent level. The arbiter also holds the two external-pin flags, each of which works in edge mode or level mode, and presents read-back views of the two priority registers.

Top module: `irq_prio_arb`

## Requirements
- R1: While `glb_en` is 0, `irq_req` is 0 whatever is pending.
- R2: A source whose bit in `src_en` is 0 never wins and never raises `irq_req`.
- R3: The level of source i is {`prio_hi[i]`,`prio_lo[i]`} (0 lowest, 3 highest). The eligible request with the highest level wins. When levels tie, the lower index wins. The indices are: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 brownout, 5 ADC, 6 edge detect.
- R4: With nothing in service, any eligible request raises `irq_req`. Otherwise `irq_req` rises only for a winner whose level is strictly above the highest level in service. A request at an equal or lower level waits.
- R5: When `ack` and `irq_req` are both 1 at a clock edge and `reti` is 0, then in the next cycle `vec_valid` is 1 and `vec_idx` holds the winner. `vec_idx` keeps that value until the next accepted acknowledge. An `ack` without `irq_req` has no effect.
- R6: A `reti` pulse removes the highest level in service. An `ack` in the same cycle as `reti` is ignored. A `reti` with nothing in service does nothing.
- R7: In edge mode (`ext_edge[k]`=1), `ext_flag[k]` becomes 1 in the cycle after a high-to-low transition of `ext_pin_n[k]`. It stays 1 until its own vector is accepted, and is 0 in the same cycle as that `vec_valid`. A new edge in the accepting cycle wins over the clear.
- R8: In level mode (`ext_edge[k]`=0), `ext_flag[k]` equals the inverse of `ext_pin_n[k]` delayed by one cycle. Accepting its vector does not clear it.
- R9: `tmr_clr[k]` is 1 for exactly the cycle in which `vec_valid` presents timer k (index 1 for timer 0, index 3 for timer 1), and 0 otherwise.
- R10: Bits 6..0 of `prio_hi_rd` and `prio_lo_rd` mirror `prio_hi` and `prio_lo`. Bit 7, which has no source, reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 7 | Per-source enables, by source index |
| prio_hi | input | 7 | High bit of each source's level |
| prio_lo | input | 7 | Low bit of each source's level |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | Per-pin mode: 1 edge, 0 level |
| tmr_ovf | input | 2 | Timer overflow flags from the timer block |
| bo_req | input | 1 | Brownout request |
| adc_req | input | 1 | ADC completion request |
| edge_req | input | 1 | Edge-detect request |
| ack | input | 1 | CPU accepts the current request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | A request may be taken now |
| vec_valid | output | 1 | One-cycle strobe for an accepted vector |
| vec_idx | output | 3 | Index of the last accepted source |
| tmr_clr | output | 2 | Overflow clear pulse to each timer |
| ext_flag | output | 2 | External-pin interrupt flags |
| prio_hi_rd | output | 8 | Read-back of the high priority bits |
| prio_lo_rd | output | 8 | Read-back of the low priority bits |

## Verification
Several sources are raised at level 0 at once, so the fixed index order is the only thing that decides the winner. The winner at that level then stays in service while other requests rise to the same level and then above it. This separates strict preemption from greater-or-equal preemption. The service record is unwound with `ack` and `reti` together and then with `reti` alone, to show that the pop wins and that the lowest pending request returns once the record is empty. Both pins are exercised in each mode: a short falling pulse shows that edge mode latches the flag, and a held low level shows that level mode follows the pin and survives vectoring. A long random phase with random levels, enables, pins, acknowledges and returns is compared every cycle with a queue-based model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVLW   = 2;            // high bit + low bit
  localparam int NLVL   = 1 << LVLW;    // four nesting levels
  localparam int NPAIR  = 2;            // external pins and timers
  localparam int NEXTRA = 3;            // brownout, ADC, edge detect
  localparam int NSRC   = 2 * NPAIR + NEXTRA;
  localparam int IDXW   = $clog2(NSRC);
  typedef logic [LVLW-1:0] lvl_t;
  typedef logic [IDXW-1:0] idx_t;
endpackage

// File: rtl/irq_ext_flag.sv
module irq_ext_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic flag
);
  logic pin_q;
  logic flag_d;
  logic fall;

  assign fall = pin_q & ~pin_n;

  always_comb begin
    if (edge_mode) begin
      flag_d = flag;
      if (clr)  flag_d = 1'b0;
      if (fall) flag_d = 1'b1;
    end else begin
      flag_d = ~pin_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
      flag  <= 1'b0;
    end else begin
      pin_q <= pin_n;
      flag  <= flag_d;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 7,
  parameter int LVLW = 2,
  parameter int IDXW = 3
) (
  input  logic [NSRC-1:0]      elig,
  input  logic [NSRC*LVLW-1:0] lvl_flat,
  output logic                 found,
  output logic [IDXW-1:0]      win_idx,
  output logic [LVLW-1:0]      win_lvl
);
  // Scan from the highest index down; ">=" lets a lower index take a tie.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!found || lvl_flat[i*LVLW +: LVLW] >= win_lvl)) begin
        found   = 1'b1;
        win_idx = IDXW'(i);
        win_lvl = lvl_flat[i*LVLW +: LVLW];
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest #(
  parameter int NLVL = 4,
  parameter int LVLW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [LVLW-1:0] push_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] isv_mask,
  output logic            busy,
  output logic [LVLW-1:0] cur_lvl
);
  logic [NLVL-1:0] mask_d;

  // Levels in service are strictly increasing, so a bit mask is a stack.
  always_comb begin
    busy    = |isv_mask;
    cur_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isv_mask[l]) cur_lvl = LVLW'(l);
    end
    mask_d = isv_mask;
    if (pop && busy)  mask_d[cur_lvl]  = 1'b0;
    else if (push)    mask_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isv_mask <= '0;
    else        isv_mask <= mask_d;
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int RDW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  prio_hi,
  input  logic [NSRC-1:0]  prio_lo,
  input  logic [NPAIR-1:0] ext_pin_n,
  input  logic [NPAIR-1:0] ext_edge,
  input  logic [NPAIR-1:0] tmr_ovf,
  input  logic             bo_req,
  input  logic             adc_req,
  input  logic             edge_req,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic             vec_valid,
  output logic [IDXW-1:0]  vec_idx,
  output logic [NPAIR-1:0] tmr_clr,
  output logic [NPAIR-1:0] ext_flag,
  output logic [RDW-1:0]   prio_hi_rd,
  output logic [RDW-1:0]   prio_lo_rd
);
  localparam int IDX_BO  = 2 * NPAIR;
  localparam int IDX_ADC = IDX_BO + 1;
  localparam int IDX_EDG = IDX_BO + 2;

  logic [NSRC-1:0]      pend;
  logic [NSRC-1:0]      elig;
  logic [NSRC*LVLW-1:0] lvl_flat;
  logic                 found;
  idx_t                 win_idx;
  lvl_t                 win_lvl;
  logic [NLVL-1:0]      isv_mask;
  logic                 busy;
  lvl_t                 cur_lvl;
  logic                 take;
  logic [NPAIR-1:0]     ext_clr;

  logic                 vv_d;
  idx_t                 idx_d;
  logic [NPAIR-1:0]     tclr_d;

  genvar k;
  generate
    for (k = 0; k < NPAIR; k++) begin : g_pair
      assign pend[2*k]     = ext_flag[k];
      assign pend[2*k + 1] = tmr_ovf[k];
      assign ext_clr[k]    = take && (win_idx == IDXW'(2*k));
      assign tclr_d[k]     = take && (win_idx == IDXW'(2*k + 1));

      irq_ext_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (ext_pin_n[k]),
        .edge_mode (ext_edge[k]),
        .clr       (ext_clr[k]),
        .flag      (ext_flag[k])
      );
    end
  endgenerate

  assign pend[IDX_BO]  = bo_req;
  assign pend[IDX_ADC] = adc_req;
  assign pend[IDX_EDG] = edge_req;

  assign elig = pend & src_en & {NSRC{glb_en}};

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_lvl
      assign lvl_flat[s*LVLW +: LVLW] = {prio_hi[s], prio_lo[s]};
    end
    for (s = 0; s < RDW; s++) begin : g_rd
      if (s < NSRC) begin : g_impl
        assign prio_hi_rd[s] = prio_hi[s];
        assign prio_lo_rd[s] = prio_lo[s];
      end else begin : g_none
        assign prio_hi_rd[s] = 1'b1;
        assign prio_lo_rd[s] = 1'b1;
      end
    end
  endgenerate

  irq_pick #(.NSRC(NSRC), .LVLW(LVLW), .IDXW(IDXW)) u_pick (
    .elig     (elig),
    .lvl_flat (lvl_flat),
    .found    (found),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign irq_req = found && (!busy || (win_lvl > cur_lvl));
  assign take    = ack && irq_req && !reti;

  irq_nest #(.NLVL(NLVL), .LVLW(LVLW)) u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take),
    .push_lvl (win_lvl),
    .pop      (reti),
    .isv_mask (isv_mask),
    .busy     (busy),
    .cur_lvl  (cur_lvl)
  );

  always_comb begin
    vv_d  = take;
    idx_d = take ? win_idx : vec_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_idx   <= '0;
      tmr_clr   <= '0;
    end else begin
      vec_valid <= vv_d;
      vec_idx   <= idx_d;
      tmr_clr   <= tclr_d;
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int NPAIR = 2,
  parameter int NLVL  = 4,
  parameter int IDXW  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             irq_req,
  input logic             ack,
  input logic             reti,
  input logic             vec_valid,
  input logic [IDXW-1:0]  vec_idx,
  input logic [NPAIR-1:0] tmr_clr,
  input logic [NPAIR-1:0] ext_edge,
  input logic [NPAIR-1:0] ext_pin_n,
  input logic [NPAIR-1:0] ext_flag,
  input logic [NLVL-1:0]  isv_mask
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req);

  assert_vec_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && vec_valid) |-> $past(ack && irq_req && !reti));

  assert_vec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !vec_valid) |-> $stable(vec_idx));

  assert_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && vec_valid) |-> ($countones(isv_mask) == $countones($past(isv_mask)) + 1));

  assert_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(reti && (isv_mask != '0))) |->
      ($countones(isv_mask) + 1 == $countones($past(isv_mask))));

  genvar k;
  generate
    for (k = 0; k < NPAIR; k++) begin : g_k
      assert_tclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr[k] |-> (vec_valid && vec_idx == IDXW'(2*k + 1)));
      assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!ext_edge[k])) |-> (ext_flag[k] == !$past(ext_pin_n[k])));
    end
  endgenerate
endmodule

bind irq_prio_arb irq_arb_chk #(.NPAIR(NPAIR), .NLVL(NLVL), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .irq_req   (irq_req),
  .ack       (ack),
  .reti      (reti),
  .vec_valid (vec_valid),
  .vec_idx   (vec_idx),
  .tmr_clr   (tmr_clr),
  .ext_edge  (ext_edge),
  .ext_pin_n (ext_pin_n),
  .ext_flag  (ext_flag),
  .isv_mask  (isv_mask)
);

// File: tb/irq_prio_arb_bench.sv
module irq_prio_arb_bench;
  logic       clk = 0;
  logic       rst_n;
  logic       glb_en;
  logic [6:0] src_en, prio_hi, prio_lo;
  logic [1:0] ext_pin_n, ext_edge, tmr_ovf;
  logic       bo_req, adc_req, edge_req, ack, reti;
  logic       irq_req, vec_valid;
  logic [2:0] vec_idx;
  logic [1:0] tmr_clr, ext_flag;
  logic [7:0] prio_hi_rd, prio_lo_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_prio_arb u_irq_prio_arb (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_en(src_en),
    .prio_hi(prio_hi), .prio_lo(prio_lo), .ext_pin_n(ext_pin_n),
    .ext_edge(ext_edge), .tmr_ovf(tmr_ovf), .bo_req(bo_req),
    .adc_req(adc_req), .edge_req(edge_req), .ack(ack), .reti(reti),
    .irq_req(irq_req), .vec_valid(vec_valid), .vec_idx(vec_idx),
    .tmr_clr(tmr_clr), .ext_flag(ext_flag),
    .prio_hi_rd(prio_hi_rd), .prio_lo_rd(prio_lo_rd)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int   m_q[$];
  bit   m_vv;
  int   m_idx;
  int   m_tclr;
  bit [1:0] m_flag, m_prev;

  function automatic bit m_pend(int s);
    case (s)
      0: return m_flag[0];
      1: return tmr_ovf[0];
      2: return m_flag[1];
      3: return tmr_ovf[1];
      4: return bo_req;
      5: return adc_req;
      default: return edge_req;
    endcase
  endfunction

  function automatic void m_pick(output bit req, output int idx, output int lvl);
    req = 0; idx = 0; lvl = 0;
    for (int L = 3; L >= 0; L--) begin
      for (int s = 0; s < 7; s++) begin
        if (!req && glb_en && src_en[s] && m_pend(s) && (2*prio_hi[s] + prio_lo[s]) == L) begin
          req = 1; idx = s; lvl = L;
        end
      end
    end
    if (req && m_q.size() > 0 && lvl <= m_q[$]) req = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_vv = 0; m_idx = 0; m_tclr = 0; m_flag = 0; m_prev = 2'b11;
    end else begin
      bit r; int i; int l; bit tk;
      m_pick(r, i, l);
      tk = ack && r && !reti;
      if (reti && m_q.size() > 0) void'(m_q.pop_back());
      if (tk) m_q.push_back(l);
      m_vv = tk;
      if (tk) m_idx = i;
      m_tclr = !tk ? 0 : (i == 1) ? 1 : (i == 3) ? 2 : 0;
      for (int k = 0; k < 2; k++) begin
        if (ext_edge[k]) begin
          if (m_prev[k] && !ext_pin_n[k]) m_flag[k] = 1;
          else if (tk && i == 2*k) m_flag[k] = 0;
        end else begin
          m_flag[k] = !ext_pin_n[k];
        end
      end
      m_prev = ext_pin_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit r; int i; int l;
      m_pick(r, i, l);
      chk("R3/R4 irq_req", irq_req, r);
      chk("R5 vec_valid", vec_valid, m_vv);
      chk("R5 vec_idx", vec_idx, m_idx);
      chk("R9 tmr_clr", tmr_clr, m_tclr);
      chk("R7/R8 ext_flag", ext_flag, m_flag);
      chk("R10 prio_hi_rd", prio_hi_rd, {1'b1, prio_hi});
      chk("R10 prio_lo_rd", prio_lo_rd, {1'b1, prio_lo});
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic take_vec();
    ack = 1; step(); ack = 0;
  endtask

  task automatic ret();
    reti = 1; step(); reti = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; glb_en = 0; src_en = 0; prio_hi = 0; prio_lo = 0;
    ext_pin_n = 2'b11; ext_edge = 2'b11; tmr_ovf = 0;
    bo_req = 0; adc_req = 0; edge_req = 0; ack = 0; reti = 0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    step();
    // reset state and read-back (R10)
    chk("R5 reset vec_valid", vec_valid, 0);
    chk("R4 reset irq_req", irq_req, 0);
    chk("R10 reset read", prio_hi_rd, 8'h80);
    prio_hi = 7'b0000101; #1;
    chk("R10 mirror", prio_hi_rd, 8'h85);
    prio_hi = 0;
    // R1 global gate
    src_en = 7'h7f; tmr_ovf = 2'b01; #1;
    chk("R1 gated", irq_req, 0);
    glb_en = 1; #1;
    chk("R1 open", irq_req, 1);
    // R2 per-source enable
    src_en = 7'h7d; #1;
    chk("R2 masked", irq_req, 0);
    src_en = 7'h7f;
    // R3 tie order at level 0
    tmr_ovf = 2'b11; bo_req = 1; step();
    take_vec();
    chk("R3 tie winner", vec_idx, 1);
    chk("R9 clear timer0", tmr_clr, 1);
    tmr_ovf[0] = 0; #1;
    chk("R4 equal level waits", irq_req, 0);
    step();
    chk("R5 strobe one cycle", vec_valid, 0);
    chk("R5 index held", vec_idx, 1);
    // R4 strictly higher preempts
    prio_hi[4] = 1; #1;
    chk("R4 higher preempts", irq_req, 1);
    take_vec();
    chk("R3 level winner", vec_idx, 4);
    chk("R9 no timer clear", tmr_clr, 0);
    bo_req = 0; adc_req = 1; prio_hi[5] = 1; #1;
    chk("R4 equal level 2 waits", irq_req, 0);
    prio_lo[5] = 1; #1;
    chk("R4 level 3 preempts", irq_req, 1);
    take_vec();
    chk("R3 adc wins", vec_idx, 5);
    adc_req = 0;
    // R5 ack without request
    take_vec();
    chk("R5 ack ignored", vec_valid, 0);
    // R6 ack with reti ignored, then unwind
    ack = 1; reti = 1; step(); ack = 0; reti = 0;
    chk("R6 ack with reti ignored", vec_valid, 0);
    chk("R6 pending after one pop", irq_req, 0);
    ret();
    chk("R6 still nested", irq_req, 0);
    ret();
    chk("R6 empty returns request", irq_req, 1);
    take_vec();
    chk("R6 timer1 served", vec_idx, 3);
    chk("R9 clear timer1", tmr_clr, 2);
    tmr_ovf = 0;
    ret();
    ret();
    // R7 edge mode
    ext_pin_n[0] = 0; step();
    chk("R7 edge sets flag", ext_flag[0], 1);
    ext_pin_n[0] = 1; step();
    chk("R7 flag latched", ext_flag[0], 1);
    take_vec();
    chk("R7 vector ext0", vec_idx, 0);
    chk("R7 cleared on vector", ext_flag[0], 0);
    ret();
    // R8 level mode
    ext_edge[1] = 0; ext_pin_n[1] = 0; step();
    chk("R8 follows pin", ext_flag[1], 1);
    take_vec();
    chk("R8 vector ext1", vec_idx, 2);
    chk("R8 not cleared", ext_flag[1], 1);
    ext_pin_n[1] = 1; step();
    chk("R8 follows release", ext_flag[1], 0);
    ret();
    // random phase, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      glb_en    = ($urandom % 8) != 0;
      src_en    = 7'($urandom) | 7'($urandom);
      if (n % 50 == 0) begin prio_hi = 7'($urandom); prio_lo = 7'($urandom); end
      ext_pin_n = 2'($urandom) | 2'($urandom);
      if (n % 200 == 0) ext_edge = 2'($urandom);
      tmr_ovf   = 2'($urandom) & 2'($urandom);
      bo_req    = ($urandom % 5) == 0;
      adc_req   = ($urandom % 5) == 0;
      edge_req  = ($urandom % 5) == 0;
      ack       = ($urandom % 3) == 0;
      reti      = ($urandom % 4) == 0;
    end
    @(negedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule